// File: doc/BRIEF.md
# Multi-Input Wakeup Detector

The block watches fourteen asynchronous wakeup pins and raises a wakeup request for the core supply. A pin can cause a wakeup only when its enable bit is set. Its polarity bit chooses what counts: a rising edge followed by a held high level, or a falling edge followed by a held low level. After the edge, the level must stay put for a programmable debounce count of clock cycles. A pin that qualifies sets its own sticky status bit. The request output stays high until a clear pulse arrives.

Enables and polarities live in one 32-bit configuration word. The write port is a plain strobe with data. A separate lock input blocks writes, and the word can always be read back. Each pin passes through a two-flop synchronizer before edge detection. Each pin has its own debounce counter, and the debounce length comes in on a 16-bit input.

Top module: `pin_wake_monitor`

## Requirements
- R1: After reset, the configuration readback is 0x00000000, every status bit is 0 and the wake request is 0.
- R2: A write stores bits 0 to 13 as the enables of pins 0 to 13 and bits 16 to 29 as their polarities (bit 16+x for pin x). Bits 14, 15, 30 and 31 always read 0.
- R3: While the lock input is high, a write strobe leaves the configuration unchanged. Readback works in every cycle.
- R4: With polarity 1, a rising edge on an enabled pin followed by a high level held long enough sets that pin's status bit and the wake request.
- R5: With polarity 0, a falling edge on an enabled pin followed by a held low level sets that pin's status bit and the wake request.
- R6: If the level reverts before the debounce count is reached, nothing is set. A later qualifying edge starts the count again from zero.
- R7: A pin whose enable bit is 0 never sets its status bit, whatever its activity.
- R8: Take the pin change as made before clock edge 1. With debounce length L, the status bit is still 0 after clock edge 3+L and is 1 after clock edge 4+L, provided the level is held throughout. This also holds for L = 0.
- R9: Status bits stay set until clr_status is sampled high. A clear resets all status bits to 0.
- R10: When clr_status is high in the same cycle that a pin qualifies, that pin's status bit ends up 1.
- R11: wake_req is high exactly when some pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (slow always-on clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pins | input | 14 | Asynchronous wakeup pins |
| dbc_len | input | 16 | Debounce length in clock cycles |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_lock | input | 1 | Write-protect flag; blocks writes when high |
| cfg_rdata | output | 32 | Configuration readback |
| clr_status | input | 1 | Clears all sticky status bits |
| wake_status | output | 14 | Per-pin sticky wakeup status |
| wake_req | output | 1 | Core-supply wakeup request |

## Verification
The status clear and a pin qualifying can land in the same clock cycle. A clear must not swallow a wakeup that arrives in that cycle. The bench moves a single clear pulse across five cycle offsets around the known qualification edge, which is clock edge 4+L after the pin change. Each run counts as correct when the status bit ends at 1 for every offset up to and including 4+L, and at 0 for every later offset.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NUM_PINS = 14;
  localparam int TYPE_OFS = 16;
  localparam int CFG_W    = 32;
  localparam int DBC_W    = 16;

  function automatic logic [CFG_W-1:0] cfg_mask(input int pins, input int tofs);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < pins; i++) begin
      m[i]        = 1'b1;
      m[tofs + i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg #(
  parameter int CFG_W    = 32,
  parameter int NUM_PINS = 14,
  parameter int TYPE_OFS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock,
  output logic [CFG_W-1:0] rdata,
  output logic [NUM_PINS-1:0] en,
  output logic [NUM_PINS-1:0] pol
);
  localparam logic [CFG_W-1:0] MASK = wake_pkg::cfg_mask(NUM_PINS, TYPE_OFS);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (wr && !lock) cfg_q <= wdata & MASK;
  end

  assign rdata = cfg_q;
  assign en    = cfg_q[NUM_PINS-1:0];
  assign pol   = cfg_q[TYPE_OFS +: NUM_PINS];
endmodule

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
  parameter int DBC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             en,
  input  logic             pol,
  input  logic [DBC_W-1:0] len,
  input  logic             clr,
  output logic             status
);
  logic             prev_q;
  logic             run_q;
  logic [DBC_W-1:0] cnt_q;
  logic             active;
  logic             edge_hit;
  logic             qualify;

  assign active   = pol ? level : ~level;
  assign edge_hit = en && (pol ? (level && !prev_q) : (!level && prev_q));
  assign qualify  = run_q && en && active && (cnt_q >= len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= level;
      if (edge_hit) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (!active || !en || qualify) run_q <= 1'b0;
        else                           cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (qualify) status <= 1'b1;
    else if (clr)     status <= 1'b0;
  end
endmodule

// File: rtl/pin_wake_monitor.sv
module pin_wake_monitor #(
  parameter int NUM_PINS = wake_pkg::NUM_PINS,
  parameter int TYPE_OFS = wake_pkg::TYPE_OFS,
  parameter int CFG_W    = wake_pkg::CFG_W,
  parameter int DBC_W    = wake_pkg::DBC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] wake_pins,
  input  logic [DBC_W-1:0]    dbc_len,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                cfg_lock,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                clr_status,
  output logic [NUM_PINS-1:0] wake_status,
  output logic                wake_req
);
  logic [NUM_PINS-1:0] pin_en;
  logic [NUM_PINS-1:0] pin_pol;
  logic [NUM_PINS-1:0] pin_sync;

  wake_cfg_reg #(.CFG_W(CFG_W), .NUM_PINS(NUM_PINS), .TYPE_OFS(TYPE_OFS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .lock(cfg_lock),
    .rdata(cfg_rdata), .en(pin_en), .pol(pin_pol)
  );

  wake_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_pins), .q(pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wake_debounce #(.DBC_W(DBC_W)) u_dbc (
      .clk(clk), .rst_n(rst_n), .level(pin_sync[i]), .en(pin_en[i]),
      .pol(pin_pol[i]), .len(dbc_len), .clr(clr_status), .status(wake_status[i])
    );
  end

  assign wake_req = |(wake_status & pin_en);
endmodule

// File: rtl/pin_wake_checker.sv
module pin_wake_checker #(
  parameter int NUM_PINS = 14,
  parameter int CFG_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr,
  input logic                cfg_lock,
  input logic [CFG_W-1:0]    cfg_rdata,
  input logic                clr_status,
  input logic [NUM_PINS-1:0] wake_status,
  input logic                wake_req
);
  localparam logic [CFG_W-1:0] MASK = wake_pkg::cfg_mask(NUM_PINS, wake_pkg::TYPE_OFS);

  p_lock_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_lock) |=> $stable(cfg_rdata));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~MASK) == '0);

  p_rise_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_status & ~$past(wake_status) & ~$past(cfg_rdata[NUM_PINS-1:0])) == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((wake_status & $past(wake_status)) == $past(wake_status)));

  p_req_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_status != '0));
endmodule

bind pin_wake_monitor pin_wake_checker #(.NUM_PINS(NUM_PINS), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lock(cfg_lock),
  .cfg_rdata(cfg_rdata), .clr_status(clr_status), .wake_status(wake_status),
  .wake_req(wake_req)
);

// File: tb/pin_wake_monitor_bench.sv
module pin_wake_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] wake_pins = '0;
  logic [15:0] dbc_len = 16'd3;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_lock = 1'b0;
  logic [31:0] cfg_rdata;
  logic        clr_status = 1'b0;
  logic [13:0] wake_status;
  logic        wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_wake_monitor u_pin_wake_monitor (
    .clk(clk), .rst_n(rst_n), .wake_pins(wake_pins), .dbc_len(dbc_len),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock),
    .cfg_rdata(cfg_rdata), .clr_status(clr_status), .wake_status(wake_status),
    .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step(1); cfg_wr = 1'b0;
  endtask

  task automatic clear_all();
    clr_status = 1'b1; step(1); clr_status = 1'b0; step(1);
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg_rdata, 32'h0);
    check("R1 status", {18'h0, wake_status}, 32'h0);
    check("R1 req", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_write_read();
    write_cfg(32'hFFFF_FFFF);
    check("R2 mask", cfg_rdata, 32'h3FFF_3FFF);
    write_cfg(32'h0001_0003);
    check("R2 value", cfg_rdata, 32'h0001_0003);
  endtask

  task automatic t_lock();
    cfg_lock = 1'b1;
    write_cfg(32'h2AAA_2AAA);
    check("R3 locked", cfg_rdata, 32'h0001_0003);
    cfg_lock = 1'b0;
    write_cfg(32'h0);
    check("R3 unlocked", cfg_rdata, 32'h0);
  endtask

  task automatic t_high_type();
    dbc_len = 16'd3;
    write_cfg(32'h0001_0001);
    wake_pins[0] = 1'b1; step(12);
    check("R4 status", {18'h0, wake_status}, 32'h1);
    check("R11 req on", {31'h0, wake_req}, 32'h1);
    wake_pins[0] = 1'b0; step(4);
    check("R9 sticky", {18'h0, wake_status}, 32'h1);
    clear_all();
    check("R9 cleared", {18'h0, wake_status}, 32'h0);
    check("R11 req off", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_low_type();
    wake_pins[5] = 1'b1; step(4);
    write_cfg(32'h0000_0020);
    wake_pins[5] = 1'b0; step(12);
    check("R5 status", {18'h0, wake_status}, 32'h20);
    write_cfg(32'h0);
    check("R11 disabled masks req", {31'h0, wake_req}, 32'h0);
    clear_all();
  endtask

  task automatic t_glitch();
    dbc_len = 16'd10;
    write_cfg(32'h0002_0002);
    wake_pins[1] = 1'b1; step(4); wake_pins[1] = 1'b0; step(20);
    check("R6 short pulse", {18'h0, wake_status}, 32'h0);
    wake_pins[1] = 1'b1; step(20);
    check("R6 restart", {18'h0, wake_status}, 32'h2);
    wake_pins[1] = 1'b0; step(4);
    clear_all();
  endtask

  task automatic t_disabled();
    dbc_len = 16'd2;
    write_cfg(32'h0004_0000);
    wake_pins[2] = 1'b1; step(12); wake_pins[2] = 1'b0; step(12);
    check("R7 disabled pin", {18'h0, wake_status}, 32'h0);
    check("R7 req", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_timing(input logic [15:0] len);
    dbc_len = len;
    write_cfg(32'h0008_0008);
    step(3);
    wake_pins[3] = 1'b1;
    step(3 + int'(len));
    check("R8 before", {18'h0, wake_status}, 32'h0);
    step(1);
    check("R8 at edge", {18'h0, wake_status}, 32'h8);
    wake_pins[3] = 1'b0; step(4);
    clear_all();
  endtask

  task automatic t_collide();
    dbc_len = 16'd3;
    write_cfg(32'h0010_0010);
    for (int n = 5; n <= 9; n++) begin
      wake_pins[4] = 1'b0; step(5); clear_all();
      wake_pins[4] = 1'b1;
      step(n - 1);
      clr_status = 1'b1; step(1); clr_status = 1'b0;
      step(10);
      check($sformatf("R10 clear at edge %0d", n), {31'h0, wake_status[4]},
            {31'h0, (n <= 7)});
    end
    wake_pins[4] = 1'b0; step(4); clear_all();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_write_read();
    t_lock();
    t_high_type();
    t_low_type();
    t_glitch();
    t_disabled();
    t_timing(16'd5);
    t_timing(16'd0);
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule